// File: doc/BRIEF.md
# Cycle Accounting Event Counter

This block is a performance-monitoring unit that sorts every core clock cycle into exactly one category and keeps a 64-bit count per category. Each cycle it sees how many instructions retired (0 to 4) and a small status bundle for the oldest instruction still in flight. The bundle gives the instruction's kind, where a pending load is being served from, whether a store port is free, and whether the memory system is busy. It also sees a flag for an empty commit buffer and a flag for a thread that has put itself to sleep.

Cycles that retire instructions go into one of three retirement bins. A cycle that retires nothing is charged to a single stall cause, picked by a fixed priority. A total-cycles counter runs alongside the category counters, so the category counters always add up to the total. Software drives a two-bit control write: one bit freezes all counting and the other clears every counter at once. It reads any counter through an address-indexed port with one cycle of latency.

Top module: `cyc_acct_top`

## Requirements
- R1: A cycle with `retired` = 1 increments category 0. A value of 2 or 3 increments category 1. A value of 4 or more (5 to 7 are treated as 4) increments category 2. A retiring cycle never increments a stall category, whatever the status inputs say.
- R2: A cycle with `retired` = 0 and `sleeping` = 1 increments category 3. This cause has the highest stall priority.
- R3: A zero-retire cycle with `sleeping` = 0 and `cse_empty` = 1 increments category 4 (fetch starvation).
- R4: A zero-retire cycle that matches no higher cause, with `head_kind` = 6 (store) and `store_port_free` = 0, increments category 5. A store whose port is free does not count here.
- R5: A zero-retire cycle that matches no higher cause, with `head_kind` = 4 (FP load) or 3 (integer load), is split by `load_src`. The codes are 0 = L1 data cache, 1 = L2, 2 or 3 = memory. FP loads use categories 6/7/8 and integer loads use 9/10/11. A load outranks `mem_busy`.
- R6: A zero-retire cycle that matches no higher cause, with `mem_busy` = 1, increments category 12.
- R7: Otherwise the head kind decides: 5 (branch) increments category 13, 2 (FP op) increments 14 and 1 (integer op) increments 15.
- R8: Any other zero-retire cycle (head kind 0, 7, or a store with a free port) increments category 16.
- R9: Every unfrozen cycle increments exactly one category counter and also the total counter at address 17. The sum of the category counters always equals the total.
- R10: A control write with bit 0 = 1 freezes counting from the next cycle on. While frozen, no counter changes. A write with bit 0 = 0 resumes counting.
- R11: A control write with bit 1 = 1 zeroes every counter at that clock edge. The clear wins over that cycle's increment.
- R12: `rd_data` shows the counter selected by `rd_addr` one clock after the address is presented. Addresses 0 to 16 select categories, 17 selects the total, and 18 to 31 read as zero.
- R13: Synchronous reset zeroes all counters and `rd_data`, and leaves counting unfrozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| retired | input | 3 | Instructions retired this cycle |
| head_kind | input | 3 | Kind of oldest in-flight instruction (0 none, 1 int op, 2 FP op, 3 int load, 4 FP load, 5 branch, 6 store, 7 misc) |
| load_src | input | 2 | Source serving the oldest load (0 L1, 1 L2, 2/3 memory) |
| store_port_free | input | 1 | At least one store port is available |
| mem_busy | input | 1 | Memory and cache system busy |
| cse_empty | input | 1 | Commit buffer holds no instructions |
| sleeping | input | 1 | Oldest instruction has suspended issue to wait for other threads |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 2 | Bit 0: freeze value; bit 1: clear pulse |
| rd_addr | input | 5 | Counter select |
| rd_data | output | 64 | Selected counter, registered |

## Verification
The hardest thing to reach from the ports is a cycle counted exactly once in isolation, and a clear that lands in the same cycle as a live increment. Because counting runs every cycle, the stimulus brackets each vector between control writes. A clear-and-freeze write comes first, then an unfreeze write; the vector is presented in the single following cycle, and a freeze write closes it. The freeze register sits one edge behind the write, so exactly one edge sees the vector. For the collision case, the clear is written while counting is live, and a zero total proves that the clear won.

// File: rtl/cyc_acct_pkg.sv
package cyc_acct_pkg;

    localparam int NCAT       = 17;
    localparam int TOTAL_ADDR = NCAT;
    localparam int ADDR_W     = 5;

    typedef enum logic [4:0] {
        CAT_RET1       = 5'd0,
        CAT_RET23      = 5'd1,
        CAT_RET4       = 5'd2,
        CAT_SLEEP      = 5'd3,
        CAT_FETCH      = 5'd4,
        CAT_STFULL     = 5'd5,
        CAT_LD_FP_L1   = 5'd6,
        CAT_LD_FP_L2   = 5'd7,
        CAT_LD_FP_MEM  = 5'd8,
        CAT_LD_INT_L1  = 5'd9,
        CAT_LD_INT_L2  = 5'd10,
        CAT_LD_INT_MEM = 5'd11,
        CAT_MEMBUSY    = 5'd12,
        CAT_BRANCH     = 5'd13,
        CAT_FP_OP      = 5'd14,
        CAT_INT_OP     = 5'd15,
        CAT_OTHER      = 5'd16
    } cat_e;

    typedef enum logic [2:0] {
        HK_NONE   = 3'd0,
        HK_INT_OP = 3'd1,
        HK_FP_OP  = 3'd2,
        HK_INT_LD = 3'd3,
        HK_FP_LD  = 3'd4,
        HK_BRANCH = 3'd5,
        HK_STORE  = 3'd6,
        HK_MISC   = 3'd7
    } head_kind_e;

    typedef enum logic [1:0] {
        SRC_L1   = 2'd0,
        SRC_L2   = 2'd1,
        SRC_MEM  = 2'd2,
        SRC_MEMX = 2'd3
    } ld_src_e;

    typedef struct packed {
        logic [2:0] retired;
        head_kind_e kind;
        ld_src_e    src;
        logic       sp_free;
        logic       mem_busy;
        logic       cse_empty;
        logic       sleeping;
    } cyc_status_t;

    // Load stall bucket: base per load type, offset per serving level.
    function automatic cat_e load_cat(input logic is_fp, input ld_src_e src);
        logic [4:0] base;
        logic [4:0] off;
        base = is_fp ? CAT_LD_FP_L1 : CAT_LD_INT_L1;
        case (src)
            SRC_L1:  off = 5'd0;
            SRC_L2:  off = 5'd1;
            default: off = 5'd2;
        endcase
        return cat_e'(base + off);
    endfunction

    // Fixed-priority attribution of one cycle.
    function automatic cat_e classify(input cyc_status_t s);
        cat_e c;
        if (s.retired >= 3'd4)                        c = CAT_RET4;
        else if (s.retired >= 3'd2)                   c = CAT_RET23;
        else if (s.retired == 3'd1)                   c = CAT_RET1;
        else if (s.sleeping)                          c = CAT_SLEEP;
        else if (s.cse_empty)                         c = CAT_FETCH;
        else if (s.kind == HK_STORE && !s.sp_free)    c = CAT_STFULL;
        else if (s.kind == HK_FP_LD)                  c = load_cat(1'b1, s.src);
        else if (s.kind == HK_INT_LD)                 c = load_cat(1'b0, s.src);
        else if (s.mem_busy)                          c = CAT_MEMBUSY;
        else if (s.kind == HK_BRANCH)                 c = CAT_BRANCH;
        else if (s.kind == HK_FP_OP)                  c = CAT_FP_OP;
        else if (s.kind == HK_INT_OP)                 c = CAT_INT_OP;
        else                                          c = CAT_OTHER;
        return c;
    endfunction

endpackage

// File: rtl/cyc_classifier.sv
module cyc_classifier
    import cyc_acct_pkg::*;
(
    input  cyc_status_t     st,
    output cat_e            cat,
    output logic [NCAT-1:0] inc
);

    always_comb begin
        cat = classify(st);
        inc = '0;
        for (int i = 0; i < NCAT; i++) begin
            if (cat == cat_e'(i)) inc[i] = 1'b1;
        end
    end

endmodule

// File: rtl/cyc_counter_bank.sv
module cyc_counter_bank
    import cyc_acct_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cnt_en,
    input  logic                       clr,
    input  logic [NCAT-1:0]            inc,
    output logic [NCAT-1:0][CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0]           total_q
);

    logic [CNT_W-1:0] cnt_d [NCAT];
    logic [CNT_W-1:0] total_d;

    generate
        for (genvar i = 0; i < NCAT; i++) begin : g_cnt
            assign cnt_d[i] = clr ? '0 :
                              (cnt_en && inc[i]) ? cnt_q[i] + 1'b1 : cnt_q[i];
        end
    endgenerate

    assign total_d = clr ? '0 : (cnt_en ? total_q + 1'b1 : total_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            total_q <= '0;
        end else begin
            for (int i = 0; i < NCAT; i++) cnt_q[i] <= cnt_d[i];
            total_q <= total_d;
        end
    end

    // Checker support: running sum of category counters.
    logic [CNT_W-1:0] cat_sum;
    always_comb begin
        cat_sum = '0;
        for (int i = 0; i < NCAT; i++) cat_sum = cat_sum + cnt_q[i];
    end

    assert_sum_matches_total_R9: assert property (@(posedge clk) disable iff (rst)
        cat_sum == total_q);

    assert_total_steps_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !clr) |=> total_q == $past(total_q) + 1'b1);

    assert_frozen_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !clr) |=> ($stable(total_q) && $stable(cnt_q)));

    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (total_q == '0 && cnt_q == '0));

endmodule

// File: rtl/cyc_read_port.sv
module cyc_read_port
    import cyc_acct_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [NCAT-1:0][CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0]           total_q,
    output logic [CNT_W-1:0]           rd_data
);

    localparam logic [ADDR_W-1:0] A_TOTAL = ADDR_W'(TOTAL_ADDR);

    logic [CNT_W-1:0] sel;

    always_comb begin
        sel = '0;
        if (rd_addr < A_TOTAL)       sel = cnt_q[rd_addr];
        else if (rd_addr == A_TOTAL) sel = total_q;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= sel;
    end

    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_addr > A_TOTAL) |=> rd_data == '0);

    assert_total_latency_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == A_TOTAL) |=> rd_data == $past(total_q));

endmodule

// File: rtl/cyc_acct_top.sv
module cyc_acct_top
    import cyc_acct_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        retired,
    input  logic [2:0]        head_kind,
    input  logic [1:0]        load_src,
    input  logic              store_port_free,
    input  logic              mem_busy,
    input  logic              cse_empty,
    input  logic              sleeping,
    input  logic              ctrl_we,
    input  logic [1:0]        ctrl_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data
);

    cyc_status_t                st;
    cat_e                       cat;
    logic [NCAT-1:0]            cat_inc;
    logic [NCAT-1:0][CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0]           total_q;
    logic                       freeze_q;
    logic                       clr;

    always_comb begin
        st.retired   = retired;
        st.kind      = head_kind_e'(head_kind);
        st.src       = ld_src_e'(load_src);
        st.sp_free   = store_port_free;
        st.mem_busy  = mem_busy;
        st.cse_empty = cse_empty;
        st.sleeping  = sleeping;
    end

    // Control: bit 0 holds the freeze state, bit 1 pulses a clear.
    always_ff @(posedge clk) begin
        if (rst)          freeze_q <= 1'b0;
        else if (ctrl_we) freeze_q <= ctrl_wdata[0];
    end

    assign clr = ctrl_we & ctrl_wdata[1];

    cyc_classifier u_class (
        .st  (st),
        .cat (cat),
        .inc (cat_inc)
    );

    cyc_counter_bank #(.CNT_W(CNT_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (!freeze_q),
        .clr     (clr),
        .inc     (cat_inc),
        .cnt_q   (cnt_q),
        .total_q (total_q)
    );

    cyc_read_port #(.CNT_W(CNT_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (rd_addr),
        .cnt_q   (cnt_q),
        .total_q (total_q),
        .rd_data (rd_data)
    );

    assert_one_category_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot(cat_inc));

    assert_retire_bins_R1: assert property (@(posedge clk) disable iff (rst)
        (retired != 3'd0) |-> (cat_inc[2:0] != 3'b000));

    assert_sleep_first_R2: assert property (@(posedge clk) disable iff (rst)
        (retired == 3'd0 && sleeping) |-> cat_inc[CAT_SLEEP]);

endmodule

// File: tb/tb_cyc_acct_top.sv
`timescale 1ns/1ps
module tb_cyc_acct_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  retired;
    logic [2:0]  head_kind;
    logic [1:0]  load_src;
    logic        store_port_free;
    logic        mem_busy;
    logic        cse_empty;
    logic        sleeping;
    logic        ctrl_we;
    logic [1:0]  ctrl_wdata;
    logic [4:0]  rd_addr;
    logic [63:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    cyc_acct_top dut (
        .clk(clk), .rst(rst), .retired(retired), .head_kind(head_kind),
        .load_src(load_src), .store_port_free(store_port_free),
        .mem_busy(mem_busy), .cse_empty(cse_empty), .sleeping(sleeping),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    // Fields: retired[16:14] kind[13:11] src[10:9] spfree[8] busy[7] cse[6] sleep[5] expected[4:0]
    localparam int NV = 21;
    localparam logic [16:0] VEC [NV] = '{
        {3'd1, 3'd7, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0},
        {3'd2, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd1},
        {3'd3, 3'd6, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd1},
        {3'd4, 3'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd2},
        {3'd5, 3'd4, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 5'd2},
        {3'd0, 3'd6, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd3},
        {3'd0, 3'd6, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd4},
        {3'd0, 3'd6, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd5},
        {3'd0, 3'd6, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd16},
        {3'd0, 3'd4, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd6},
        {3'd0, 3'd4, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd7},
        {3'd0, 3'd4, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'd8},
        {3'd0, 3'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd9},
        {3'd0, 3'd3, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 5'd10},
        {3'd0, 3'd3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 5'd11},
        {3'd0, 3'd5, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd12},
        {3'd0, 3'd5, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd13},
        {3'd0, 3'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd14},
        {3'd0, 3'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'd15},
        {3'd0, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd16},
        {3'd0, 3'd7, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd16}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_stim(input logic [16:0] v);
        retired         = v[16:14];
        head_kind       = v[13:11];
        load_src        = v[10:9];
        store_port_free = v[8];
        mem_busy        = v[7];
        cse_empty       = v[6];
        sleeping        = v[5];
    endtask

    // Called at a negedge; returns at the next negedge with the registered result.
    task automatic rd(input logic [4:0] a, output logic [63:0] d);
        ctrl_we = 1'b0;
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    // Called at a negedge: one control write taking effect at the next edge.
    task automatic ctl(input logic [1:0] w);
        ctrl_we    = 1'b1;
        ctrl_wdata = w;
        @(negedge clk);
        ctrl_we    = 1'b0;
    endtask

    task automatic summary_and_end;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
            summary_and_end();
        end
    end

    initial begin
        logic [63:0] d;
        logic [63:0] sum;
        rst = 1'b1; ctrl_we = 1'b0; ctrl_wdata = 2'b00; rd_addr = 5'd17;
        set_stim({3'd0, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0});
        repeat (3) @(negedge clk);
        chk("R13 rd_data in reset", rd_data, 64'd0);
        rst = 1'b0;
        rd(5'd17, d);
        chk("R13 total right after reset", d, 64'd0);

        // Table walk: each vector counted in exactly one cycle.
        for (int i = 0; i < NV; i++) begin
            logic [4:0] e;
            e = VEC[i][4:0];
            set_stim({3'd0, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0});
            ctl(2'b11);              // clear and freeze
            set_stim(VEC[i]);
            ctl(2'b00);              // unfreeze; this edge still frozen
            ctl(2'b01);              // this edge counts the vector, then freeze
            rd(e, d);
            chk($sformatf("R1-R8 vec %0d category %0d (R1 R2 R3 R4 R5 R6 R7 R8)", i, e), d, 64'd1);
            rd(5'd17, d);
            chk($sformatf("R9 vec %0d total", i), d, 64'd1);
            rd(5'((e + 5'd1) % 5'd17), d);
            chk($sformatf("R9 vec %0d neighbour of %0d", i, e), d, 64'd0);
        end

        // R10: frozen cycles with busy stimulus do not count; three unfrozen ones do.
        set_stim({3'd0, 3'd5, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0});
        ctl(2'b11);
        repeat (3) @(negedge clk);
        rd(5'd17, d);
        chk("R10 total while frozen", d, 64'd0);
        rd(5'd12, d);
        chk("R10 busy count while frozen", d, 64'd0);
        ctl(2'b00);
        @(negedge clk);
        @(negedge clk);
        ctl(2'b01);
        rd(5'd17, d);
        chk("R10 total after three live cycles", d, 64'd3);
        rd(5'd12, d);
        chk("R10 busy count after three live cycles", d, 64'd3);

        // R9: mixed sequence, sum of categories equals total.
        ctl(2'b11);
        ctl(2'b00);
        set_stim({3'd4, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0});
        @(negedge clk);
        set_stim({3'd0, 3'd3, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0});
        @(negedge clk);
        set_stim({3'd0, 3'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0});
        @(negedge clk);
        set_stim({3'd2, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0});
        ctl(2'b01);
        sum = 64'd0;
        for (int a = 0; a < 17; a++) begin
            rd(5'(a), d);
            sum = sum + d;
        end
        chk("R9 category sum", sum, 64'd4);
        rd(5'd17, d);
        chk("R9 total of mixed run", d, 64'd4);
        rd(5'd10, d);
        chk("R5 int load from L2 in mixed run", d, 64'd1);

        // R12: unmapped addresses read zero while counters are nonzero.
        rd(5'd18, d);
        chk("R12 address 18", d, 64'd0);
        rd(5'd31, d);
        chk("R12 address 31", d, 64'd0);
        rd(5'd2, d);
        chk("R12 mapped address after unmapped", d, 64'd1);

        // R11: clear written during a live counting cycle wins.
        ctl(2'b00);
        @(negedge clk);
        ctl(2'b11);
        rd(5'd17, d);
        chk("R11 total after clear on live cycle", d, 64'd0);
        rd(5'd1, d);
        chk("R11 retire bin after clear on live cycle", d, 64'd0);

        summary_and_end();
    end

endmodule